// File: doc/BRIEF.md
# Card Test State Sequencer

This block drives the second half of a card tester's test cycle. Starting from idle, it powers up the probe and runs the functional test. It then powers the probe down, reconnects the card under test and decides whether to run another pass. Each step waits for a sensed physical condition before moving on: a supply-good flag, a test-finished pulse, a supply-off flag or a reed-switch-closed flag. The threshold comparators, relays and functional test logic are outside the block. The block only sees their digital flags.

After the reed switch reports closure, a cycle-counting one-shot holds the sequence for a fixed settle time before the decision step. The default length of this one-shot is 47 ms of a 250 MHz clock. At the decision step, the sequence goes back to a configurable restart step if the continuous switch is on or the repeat button was pressed. Otherwise it returns to idle and waits for a new start. The repeat button is asynchronous. The block synchronizes it and reduces each press to one event.

Top module: `card_test_seq`

## Requirements
- R1: After reset, `state_o` reads 0 (idle) and `probe_pwr_en_o`, `test_start_o` and `reed_close_o` are all low.
- R2: In idle, only `start_i` has any effect. It moves the state to 6 on the next clock. All other inputs leave the state and outputs unchanged.
- R3: In state 6, `probe_pwr_en_o` is high. The state moves to 7 only on a clock where `pwr_good_i` is high.
- R4: `test_start_o` is high for exactly one cycle: the first cycle of each visit to state 7. It is low at every other time.
- R5: In state 7, `probe_pwr_en_o` stays high. The state moves to 8 only on a clock where `test_done_i` is high.
- R6: In state 8, `probe_pwr_en_o` is low. The state moves to 9 only on a clock where `pwr_off_i` is high.
- R7: In states 9 and 10, `reed_close_o` is high, and it is low in every other state. In state 9, the first clock that samples `reed_closed_i` high starts a settle timer. State 10 is entered exactly `SETTLE_CYCLES` clocks after that clock. Changes on `reed_closed_i` while the timer runs neither restart nor extend it.
- R8: State 10 lasts one cycle. On the next clock, the state goes to `RESTART_STATE` if `cont_cycle_i` is high or a repeat event is pending. Otherwise it goes to 0.
- R9: `repeat_btn_i` passes through two synchronizer stages, and only its rising edge counts, so a held button is one event. An event seen while the sequence is active stays pending until the next state-10 decision consumes it. An event seen in idle is discarded.
- R10: `state_o` is 4 bits wide: idle is 0, and the active steps are 6, 7, 8, 9 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a sequence from idle |
| pwr_good_i | input | 1 | Probe supply above the power-up threshold |
| pwr_off_i | input | 1 | Probe supply below the power-down threshold |
| reed_closed_i | input | 1 | Reed switch reports closed |
| test_done_i | input | 1 | Functional test finished |
| cont_cycle_i | input | 1 | Continuous cycling switch |
| repeat_btn_i | input | 1 | Repeat pushbutton, asynchronous |
| probe_pwr_en_o | output | 1 | Probe power enable |
| test_start_o | output | 1 | One-cycle start pulse to the functional test |
| reed_close_o | output | 1 | Command the reed switch closed |
| state_o | output | 4 | Current step code |

## Verification
The bench builds the block with `SETTLE_CYCLES` set to 20, so the settle window and its exact end fit in a short run. The bench also times that window from the closure edge. `RESTART_STATE` is left at 6, so every continuation passes again through power-up, the start pulse and power-down. Both restart triggers are exercised: the continuous switch and a repeat press. The repeat runs include a button held across many cycles, a press made in idle that must be dropped, and toggling of the reed flag during the settle window.

// File: rtl/cts_pkg.sv
package cts_pkg;
  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_PWRUP  = 4'd6,
    ST_TEST   = 4'd7,
    ST_PWRDN  = 4'd8,
    ST_RECON  = 4'd9,
    ST_DECIDE = 4'd10
  } step_e;
endpackage

// File: rtl/cts_rst_sync.sv
module cts_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sh_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end
  assign rst_no = sh_q[1];
endmodule

// File: rtl/cts_btn_event.sv
module cts_btn_event #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic event_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], btn_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign event_o = sync_q[SYNC_STAGES-1] & ~last_q;

  // R9: a held button gives no second event
  p_single_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);
endmodule

// File: rtl/cts_oneshot.sv
module cts_oneshot #(
  parameter int unsigned CYCLES = 32'd11_750_000,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign busy_o   = (cnt_q != '0);
  assign expire_o = (cnt_q == CNT_W'(1));
  assign cnt_en   = busy_o | trig_i;

  always_comb begin
    cnt_d = cnt_q;
    if (!busy_o && trig_i) cnt_d = CNT_W'(CYCLES);
    else if (busy_o)       cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7: a running timer only counts down, a trigger never reloads it
  p_no_retrigger_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/cts_fsm.sv
module cts_fsm
  import cts_pkg::*;
#(
  parameter step_e RESTART = ST_PWRUP
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       pwr_good_i,
  input  logic       pwr_off_i,
  input  logic       reed_closed_i,
  input  logic       test_done_i,
  input  logic       cont_cycle_i,
  input  logic       rep_event_i,
  input  logic       settle_busy_i,
  input  logic       settle_done_i,
  output logic       settle_trig_o,
  output logic       probe_pwr_en_o,
  output logic       test_start_o,
  output logic       reed_close_o,
  output logic [3:0] state_o
);
  step_e st_q, st_d;
  logic  pend_q, pend_d;
  logic  pulse_q, pulse_d;
  logic  go_again;

  assign go_again = cont_cycle_i | pend_q | rep_event_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_i)       st_d = ST_PWRUP;
      ST_PWRUP:  if (pwr_good_i)    st_d = ST_TEST;
      ST_TEST:   if (test_done_i)   st_d = ST_PWRDN;
      ST_PWRDN:  if (pwr_off_i)     st_d = ST_RECON;
      ST_RECON:  if (settle_done_i) st_d = ST_DECIDE;
      ST_DECIDE: st_d = go_again ? RESTART : ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_d  = (st_q != ST_IDLE) && (st_q != ST_DECIDE) && (pend_q || rep_event_i);
    pulse_d = (st_d == ST_TEST) && (st_q != ST_TEST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
    end
  end

  assign settle_trig_o  = (st_q == ST_RECON) && reed_closed_i && !settle_busy_i;
  assign probe_pwr_en_o = (st_q == ST_PWRUP) || (st_q == ST_TEST);
  assign reed_close_o   = (st_q == ST_RECON) || (st_q == ST_DECIDE);
  assign test_start_o   = pulse_q;
  assign state_o        = st_q;

  p_hold_pwrup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PWRUP && !pwr_good_i) |=> (st_q == ST_PWRUP));
  p_start_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_start_o |=> !test_start_o);
  p_start_in_test_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_start_o |-> (st_q == ST_TEST));
  p_hold_test_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TEST && !test_done_i) |=> (st_q == ST_TEST));
  p_hold_pwrdn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PWRDN && !pwr_off_i) |=> (st_q == ST_PWRDN));
  p_decide_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DECIDE) |=> (st_q != ST_DECIDE));
  p_idle_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !start_i) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/card_test_seq.sv
module card_test_seq
  import cts_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 32'd11_750_000,
  parameter int unsigned RESTART_STATE = 32'd6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       pwr_good_i,
  input  logic       pwr_off_i,
  input  logic       reed_closed_i,
  input  logic       test_done_i,
  input  logic       cont_cycle_i,
  input  logic       repeat_btn_i,
  output logic       probe_pwr_en_o,
  output logic       test_start_o,
  output logic       reed_close_o,
  output logic [3:0] state_o
);
  localparam step_e RESTART_STEP =
    (RESTART_STATE == 32'd7) ? ST_TEST  :
    (RESTART_STATE == 32'd8) ? ST_PWRDN :
    (RESTART_STATE == 32'd9) ? ST_RECON : ST_PWRUP;

  logic rst_n_int;
  logic rep_event;
  logic settle_trig, settle_busy, settle_done;

  cts_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  cts_btn_event #(.SYNC_STAGES(2)) u_btn (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .btn_i   (repeat_btn_i),
    .event_o (rep_event)
  );

  cts_oneshot #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .trig_i   (settle_trig),
    .busy_o   (settle_busy),
    .expire_o (settle_done)
  );

  cts_fsm #(.RESTART(RESTART_STEP)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_n_int),
    .start_i        (start_i),
    .pwr_good_i     (pwr_good_i),
    .pwr_off_i      (pwr_off_i),
    .reed_closed_i  (reed_closed_i),
    .test_done_i    (test_done_i),
    .cont_cycle_i   (cont_cycle_i),
    .rep_event_i    (rep_event),
    .settle_busy_i  (settle_busy),
    .settle_done_i  (settle_done),
    .settle_trig_o  (settle_trig),
    .probe_pwr_en_o (probe_pwr_en_o),
    .test_start_o   (test_start_o),
    .reed_close_o   (reed_close_o),
    .state_o        (state_o)
  );

  // R7: the reed command never coexists with probe power
  p_reed_vs_power_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    reed_close_o |-> !probe_pwr_en_o);
endmodule

// File: tb/sim_card_test_seq.sv
module sim_card_test_seq;
  localparam int SETTLE  = 20;
  localparam int RESTART = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic start, pg, poff, reed, done, cont, btn;
  logic pwr_en, tstart, rclose;
  logic [3:0] st;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  card_test_seq #(.SETTLE_CYCLES(SETTLE), .RESTART_STATE(RESTART)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pwr_good_i(pg),
    .pwr_off_i(poff), .reed_closed_i(reed), .test_done_i(done),
    .cont_cycle_i(cont), .repeat_btn_i(btn),
    .probe_pwr_en_o(pwr_en), .test_start_o(tstart),
    .reed_close_o(rclose), .state_o(st));

  // behavioural reference
  int m_st = 0, m_left = 0, m_pend = 0, m_start = 0;
  int btn_hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_left = 0; m_pend = 0; m_start = 0;
      btn_hist = '{0, 0, 0};
    end else begin
      int nst, press;
      press = (btn_hist[1] == 1 && btn_hist[2] == 0);
      nst = m_st;
      if (m_st == 0 && start) nst = 6;
      else if (m_st == 6 && pg) nst = 7;
      else if (m_st == 7 && done) nst = 8;
      else if (m_st == 8 && poff) nst = 9;
      else if (m_st == 9 && m_left == 1) nst = 10;
      else if (m_st == 10) nst = (cont || m_pend || press) ? RESTART : 0;
      if (m_left > 0) m_left = m_left - 1;
      else if (m_st == 9 && reed) m_left = SETTLE;
      m_pend = (m_st != 0 && m_st != 10 && (m_pend || press)) ? 1 : 0;
      m_start = (nst == 7 && m_st != 7) ? 1 : 0;
      m_st = nst;
      btn_hist.push_front(int'(btn));
      void'(btn_hist.pop_back());
    end
  end

  function automatic string req_of(int s);
    case (s)
      0: return "R2";
      6: return "R3";
      7: return "R5";
      8: return "R6";
      9: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n === 1'b1) begin
      chk(int'(st) == m_st, req_of(m_st), int'(st), m_st);          // R10 codes
      chk(int'(pwr_en) == int'(m_st == 6 || m_st == 7), "R3", int'(pwr_en), int'(m_st == 6 || m_st == 7));
      chk(int'(tstart) == m_start, "R4", int'(tstart), m_start);
      chk(int'(rclose) == int'(m_st >= 9), "R7", int'(rclose), int'(m_st >= 9));
    end
    if (cyc >= 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_to_decide(int press_at_test, int hold);
    step(3);
    pg = 1; step(1); pg = 0;                    // R3 advance
    if (press_at_test != 0) begin btn = 1; step(hold); btn = 0; end
    step(4);
    done = 1; step(1); done = 0;                // R5
    step(5);
    poff = 1; step(1); poff = 0;                // R6
    step(3);
    reed = 1;
    begin
      int k = 0;
      do begin
        step(1); k++;
        reed = (k % 3 == 0);                    // toggling during count, R7
      end while (st != 4'd10 && k < 100);
      chk(k == SETTLE + 1, "R7", k, SETTLE + 1);
    end
    reed = 0;
  endtask

  initial begin
    rst_n = 0; start = 0; pg = 0; poff = 0; reed = 0; done = 0; cont = 0; btn = 0;
    step(3);
    chk(st == 4'd0 && !pwr_en && !tstart && !rclose, "R1", int'(st), 0);
    rst_n = 1; step(4);
    chk(st == 4'd0, "R1", int'(st), 0);

    // R2: idle ignores everything but start; R9: press in idle is dropped
    pg = 1; poff = 1; done = 1; reed = 1; btn = 1; step(6);
    chk(st == 4'd0 && !rclose && !pwr_en, "R2", int'(st), 0);
    pg = 0; poff = 0; done = 0; reed = 0; btn = 0; step(4);

    // single pass, terminate
    start = 1; step(1); start = 0;
    chk(st == 4'd6, "R2", int'(st), 6);
    run_to_decide(0, 1);
    step(1);
    chk(st == 4'd0, "R8", int'(st), 0);

    // continuous switch restarts
    start = 1; step(1); start = 0;
    cont = 1;
    run_to_decide(0, 1);
    step(1);
    chk(st == 4'd6, "R8", int'(st), RESTART);
    cont = 0;

    // held repeat press = one event, consumed at decision
    run_to_decide(1, 30);
    step(1);
    chk(st == 4'd6, "R9", int'(st), RESTART);
    run_to_decide(0, 1);
    step(1);
    chk(st == 4'd0, "R9", int'(st), 0);
    step(5);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule